// File: doc/BRIEF.md
# Dual-Output Compare-Action PWM Timer

This block is one timer channel running in waveform mode. A single up-counter is advanced by a selectable time base: the system clock divided by 2, 8, 32 or 128, or rising edges of a separate slow clock input that suits long periods. The counter climbs to a period value and wraps to zero on the next count. Two output pins, A and B, follow that shared counter. Each pin is set, cleared, toggled or left alone by programmable actions tied to three events: its own compare value, the shared period match and a software trigger.

Software drives the channel through a small synchronous write port and a combinational read port. It writes a mode word that holds the time-base select and the six 2-bit action fields, the two compare values and the period value. It also writes command words that start or stop counting and issue a software trigger. The trigger restarts the counter and forces each pin to its trigger action at once. With the compare actions set to none, this gives a steady 0% or 100% level.

Top module: `cmp_action_pwm`

## Requirements
- R1: After reset both outputs are low, counting is stopped, and the mode, compare, period and counter values all read as zero.
- R2: Address 0 is the mode word, address 1 the compare value of A, address 2 the compare value of B, address 3 the period, address 4 the write-only command (reads 0), and address 5 reads the counter. Values written to addresses 0 to 3 read back on the next cycle and take effect at once.
- R3: Mode bits [2:0] pick the time base. Values 0, 1, 2 and 3 give one count every 2, 8, 32 and 128 clock cycles. Values 4 to 7 give one count per rising edge of the slow clock input.
- R4: On each count the counter adds one. On the count after it equals the period value it returns to zero instead, so a period spans period+1 counts.
- R5: The action encoding is 00 none, 01 set, 10 clear, 11 toggle. For A, mode bits [4:3] hold the compare action, [6:5] the period action and [8:7] the trigger action. For B the same three fields sit at [10:9], [12:11] and [14:13]. A pin changes only on one of its events.
- R6: With period action set and compare action clear, a pin is high for compare+1 counts of every period. With the two actions swapped, the pin is low for compare+1 counts.
- R7: Both pins repeat with the one common period given by the period value.
- R8: A command with bit 2 set resets the counter and the time-base divider to zero and applies each pin's trigger action in that cycle. With the compare actions set to none, this holds a steady level.
- R9: When events coincide on one pin, the trigger decides first, then the period match, then the pin's own compare match. The highest event present selects the action.
- R10: Command bit 0 starts counting and bit 1 stops it. Both set in one write stop it. While stopped, the counter holds and no compare or period events occur. A trigger in the same write still resets the counter and applies the trigger actions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_clk | input | 1 | Slow time-base clock, sampled and edge detected |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register address for write and read |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr, combinational |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |

## Verification
The hardest state to reach is a software trigger that lands in the same cycle as a period match, because only that exposes the event priority. The stimulus starts the channel with a trigger at the smallest divider. It then counts clock edges from that known phase and reads the counter just before the predicted match edge. The second trigger is timed to register on exactly that edge, with opposing period and trigger actions on the two pins. Duty and period are checked by counting high cycles and rising edges over windows of whole periods, so those checks do not depend on phase.

// File: rtl/pwm_tc_pkg.sv
package pwm_tc_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    // per-pin action group, LSB first: compare, period, trigger
    typedef struct packed {
        act_e on_trig;
        act_e on_period;
        act_e on_cmp;
    } pin_act_t;

    localparam int ADDR_W  = 3;
    localparam int SEL_W   = 3;
    localparam int NUM_PIN = 2;
    localparam int ACT_W   = $bits(pin_act_t);
    localparam int MODE_W  = SEL_W + NUM_PIN * ACT_W;

    localparam logic [ADDR_W-1:0] ADR_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CMPA = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CMPB = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_PER  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CMD  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd5;

    localparam int CMD_START = 0;
    localparam int CMD_STOP  = 1;
    localparam int CMD_TRIG  = 2;

    function automatic logic act_apply(act_e a, logic cur);
        case (a)
            ACT_SET: act_apply = 1'b1;
            ACT_CLR: act_apply = 1'b0;
            ACT_TGL: act_apply = ~cur;
            default: act_apply = cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_tc_prescaler.sv
module pwm_tc_prescaler #(
    parameter int PSC_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] sel,
    input  logic       slow_in,
    output logic       tick
);
    typedef struct packed {
        logic [PSC_W-1:0]       psc;
        logic [SYNC_STAGES-1:0] sync;
        logic                   slow_prev;
    } psc_state_t;

    psc_state_t st_d, st_q;
    logic [PSC_W-1:0] mask;
    logic             slow_rise;

    always_comb begin
        mask      = PSC_W'((1 << (1 + 2 * int'(sel[1:0]))) - 1);
        slow_rise = st_q.sync[SYNC_STAGES-1] & ~st_q.slow_prev;
        tick      = run & (sel[2] ? slow_rise : ((st_q.psc & mask) == mask));

        st_d           = st_q;
        st_d.sync      = {st_q.sync[SYNC_STAGES-2:0], slow_in};
        st_d.slow_prev = st_q.sync[SYNC_STAGES-1];
        if (restart)
            st_d.psc = '0;
        else if (run)
            st_d.psc = st_q.psc + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    no_tick_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

endmodule

// File: rtl/pwm_tc_counter.sv
module pwm_tc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] per,
    output logic [CNT_W-1:0] cnt,
    output logic             per_hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        per_hit = tick & (st_q.cnt == per);
        st_d    = st_q;
        if (restart)
            st_d.cnt = '0;
        else if (per_hit)
            st_d.cnt = '0;
        else if (tick)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_hit |=> (st_q.cnt == '0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(st_q.cnt));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));

endmodule

// File: rtl/pwm_tc_pin.sv
module pwm_tc_pin
    import pwm_tc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             trig,
    input  logic             per_hit,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  pin_act_t         act,
    output logic             pin
);
    typedef struct packed {
        logic lvl;
    } pin_state_t;

    pin_state_t st_d, st_q;
    logic       cmp_hit;

    always_comb begin
        cmp_hit = tick & (cnt == cmp);
        st_d    = st_q;
        if (trig)
            st_d.lvl = act_apply(act.on_trig, st_q.lvl);
        else if (per_hit)
            st_d.lvl = act_apply(act.on_period, st_q.lvl);
        else if (cmp_hit)
            st_d.lvl = act_apply(act.on_cmp, st_q.lvl);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin = st_q.lvl;

    // R5
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !per_hit && !cmp_hit) |=> $stable(st_q.lvl));

    // R9
    trig_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && act.on_trig == ACT_SET) |=> st_q.lvl);

endmodule

// File: rtl/cmp_action_pwm.sv
module cmp_action_pwm
    import pwm_tc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              out_a,
    output logic              out_b
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  cmp_a;
        logic [CNT_W-1:0]  cmp_b;
        logic [CNT_W-1:0]  per;
        logic              run;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  cmd_wr, trig, tick, per_hit;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cmp_arr [NUM_PIN];
    pin_act_t           act_arr [NUM_PIN];
    logic [NUM_PIN-1:0] pins;

    always_comb begin
        cmd_wr = wr_en & (addr == ADR_CMD);
        trig   = cmd_wr & wdata[CMD_TRIG];
        regs_d = regs_q;
        if (wr_en) begin
            case (addr)
                ADR_MODE: regs_d.mode  = wdata[MODE_W-1:0];
                ADR_CMPA: regs_d.cmp_a = wdata[CNT_W-1:0];
                ADR_CMPB: regs_d.cmp_b = wdata[CNT_W-1:0];
                ADR_PER:  regs_d.per   = wdata[CNT_W-1:0];
                default:  ;
            endcase
        end
        if (cmd_wr) begin
            if (wdata[CMD_STOP])
                regs_d.run = 1'b0;
            else if (wdata[CMD_START])
                regs_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (addr)
            ADR_MODE: rdata = DATA_W'(regs_q.mode);
            ADR_CMPA: rdata = DATA_W'(regs_q.cmp_a);
            ADR_CMPB: rdata = DATA_W'(regs_q.cmp_b);
            ADR_PER:  rdata = DATA_W'(regs_q.per);
            ADR_CNT:  rdata = DATA_W'(cnt);
            default:  rdata = '0;
        endcase
    end

    generate
        if (DATA_W > CNT_W) begin : g_spare
            logic unused_wdata;
            assign unused_wdata = ^wdata[DATA_W-1:CNT_W];
        end
    endgenerate

    pwm_tc_prescaler u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (regs_q.run),
        .restart (trig),
        .sel     (regs_q.mode[SEL_W-1:0]),
        .slow_in (slow_clk),
        .tick    (tick)
    );

    pwm_tc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (trig),
        .per     (regs_q.per),
        .cnt     (cnt),
        .per_hit (per_hit)
    );

    assign cmp_arr[0] = regs_q.cmp_a;
    assign cmp_arr[1] = regs_q.cmp_b;

    generate
        for (genvar g = 0; g < NUM_PIN; g++) begin : g_pin
            assign act_arr[g] = pin_act_t'(regs_q.mode[SEL_W + g*ACT_W +: ACT_W]);
            pwm_tc_pin #(.CNT_W(CNT_W)) u_pin (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .trig    (trig),
                .per_hit (per_hit),
                .cnt     (cnt),
                .cmp     (cmp_arr[g]),
                .act     (act_arr[g]),
                .pin     (pins[g])
            );
        end
    endgenerate

    assign out_a = pins[0];
    assign out_b = pins[1];

    // R10
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[CMD_STOP]) |=> !regs_q.run);

    // R10
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[CMD_START] && !wdata[CMD_STOP]) |=> regs_q.run);

endmodule

// File: tb/tb_cmp_action_pwm.sv
module tb_cmp_action_pwm;
    localparam int DATA_W = 32;
    localparam logic [1:0] NONE = 2'b00, SET = 2'b01, CLR = 2'b10, TGL = 2'b11;
    localparam logic [31:0] C_START = 32'h1, C_STOP = 32'h2, C_TRIG = 32'h4;

    logic clk = 1'b0, rst_n = 1'b0, slow_clk = 1'b0, wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic out_a, out_b;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    initial forever begin
        repeat (5) @(negedge clk);
        slow_clk = ~slow_clk;
    end

    cmp_action_pwm #(.CNT_W(16), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .out_a(out_a), .out_b(out_b)
    );

    function automatic logic [31:0] mode_word(int sel, logic [1:0] ac, logic [1:0] ap,
                                              logic [1:0] at, logic [1:0] bc,
                                              logic [1:0] bp, logic [1:0] bt);
        return {17'd0, bt, bp, bc, at, ap, ac, 3'(sel)};
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic measure(int n, output int ha, output int hb, output int ea, output int eb);
        logic pa, pb;
        ha = 0; hb = 0; ea = 0; eb = 0;
        pa = out_a; pb = out_b;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ha += int'(out_a); hb += int'(out_b);
            if (out_a && !pa) ea++;
            if (out_b && !pb) eb++;
            pa = out_a; pb = out_b;
        end
    endtask

    task automatic start(logic [31:0] m, int ra, int rb, int rc);
        wr(3'd0, m);
        wr(3'd1, 32'(ra));
        wr(3'd2, 32'(rb));
        wr(3'd3, 32'(rc));
        wr(3'd4, C_START | C_TRIG);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 out_a low", out_a, 0);
        check("R1 out_b low", out_b, 0);
        rd(3'd5, d); check("R1 counter zero", d, 0);
        rd(3'd0, d); check("R1 mode zero", d, 0);
        rd(3'd3, d); check("R1 period zero", d, 0);
        repeat (10) @(negedge clk);
        rd(3'd5, d); check("R1 clock stopped at reset", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(3'd0, 32'h5A5C); rd(3'd0, d); check("R2 mode readback", d, 32'h5A5C);
        wr(3'd1, 32'h1234); rd(3'd1, d); check("R2 cmp A readback", d, 32'h1234);
        wr(3'd2, 32'hBEEF); rd(3'd2, d); check("R2 cmp B readback", d, 32'hBEEF);
        wr(3'd3, 32'h0F0F); rd(3'd3, d); check("R2 period readback", d, 32'h0F0F);
        rd(3'd4, d); check("R2 command reads zero", d, 0);
    endtask

    task automatic t_pwm();
        int ha, hb, ea, eb;
        start(mode_word(0, CLR, SET, SET, SET, CLR, CLR), 3, 6, 9);
        repeat (40) @(negedge clk);
        measure(40, ha, hb, ea, eb);
        check("R6 normal pin high cycles", ha, 16);
        check("R6 inverted pin high cycles", hb, 12);
        check("R7 pin A periods", ea, 2);
        check("R7 pin B periods", eb, 2);
    endtask

    task automatic t_divs();
        int ha, hb, ea, eb;
        for (int s = 0; s < 4; s++) begin
            int dv;
            dv = 2 << (2 * s);
            start(mode_word(s, CLR, SET, SET, NONE, NONE, NONE), 0, 0, 2);
            repeat (6 * dv) @(negedge clk);
            measure(3 * dv, ha, hb, ea, eb);
            check($sformatf("R3 divider sel %0d high cycles", s), ha, dv);
        end
    endtask

    task automatic t_slow();
        int ha, hb, ea, eb;
        start(mode_word(4, CLR, SET, SET, NONE, NONE, NONE), 0, 0, 2);
        repeat (60) @(negedge clk);
        measure(30, ha, hb, ea, eb);
        check("R3 slow clock high cycles", ha, 10);
        check("R3 slow clock one period", ea, 1);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        start(mode_word(0, NONE, NONE, NONE, NONE, NONE, NONE), 0, 0, 3);
        repeat (7) @(posedge clk);
        @(negedge clk);
        rd(3'd5, d); check("R4 counter at period value", d, 3);
        @(posedge clk); @(negedge clk);
        rd(3'd5, d); check("R4 counter wraps to zero", d, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd(3'd5, d); check("R4 counter resumes", d, 1);
    endtask

    task automatic t_prio_trig();
        logic [31:0] d;
        start(mode_word(0, NONE, CLR, SET, NONE, SET, CLR), 0, 0, 3);
        repeat (7) @(posedge clk);
        @(negedge clk);
        rd(3'd5, d); check("R9 counter before coincident edge", d, 3);
        check("R8 trigger set A", out_a, 1);
        check("R8 trigger cleared B", out_b, 0);
        wr(3'd4, C_TRIG);
        check("R9 trigger beats period on A", out_a, 1);
        check("R9 trigger beats period on B", out_b, 0);
        rd(3'd5, d); check("R8 trigger zeroes counter", d, 0);
        repeat (8) @(posedge clk);
        @(negedge clk);
        check("R9 lone period match on A", out_a, 0);
        check("R9 lone period match on B", out_b, 1);
    endtask

    task automatic t_prio_cmp();
        int ha, hb, ea, eb;
        start(mode_word(0, CLR, SET, CLR, SET, CLR, SET), 3, 3, 3);
        repeat (20) @(negedge clk);
        measure(16, ha, hb, ea, eb);
        check("R9 period beats compare on A", ha, 16);
        check("R9 period beats compare on B", hb, 0);
    endtask

    task automatic t_toggle();
        int ha, hb, ea, eb;
        start(mode_word(0, NONE, TGL, CLR, NONE, NONE, NONE), 0, 0, 4);
        repeat (20) @(negedge clk);
        measure(40, ha, hb, ea, eb);
        check("R5 toggle high cycles", ha, 20);
        check("R5 toggle rising edges", ea, 2);
    endtask

    task automatic t_steady();
        int ha, hb, ea, eb;
        start(mode_word(0, NONE, NONE, SET, NONE, NONE, CLR), 2, 2, 5);
        measure(30, ha, hb, ea, eb);
        check("R8 steady 100% on A", ha, 30);
        check("R8 steady 0% on B", hb, 0);
        wr(3'd0, mode_word(0, NONE, NONE, CLR, NONE, NONE, SET));
        wr(3'd4, C_TRIG);
        measure(30, ha, hb, ea, eb);
        check("R8 steady 0% on A", ha, 0);
        check("R8 steady 100% on B", hb, 30);
    endtask

    task automatic t_stop();
        logic [31:0] d1, d2;
        int ha, hb, ea, eb;
        logic la;
        start(mode_word(0, CLR, SET, SET, NONE, NONE, NONE), 1, 0, 5);
        repeat (13) @(negedge clk);
        wr(3'd4, C_STOP);
        rd(3'd5, d1);
        la = out_a;
        measure(20, ha, hb, ea, eb);
        rd(3'd5, d2);
        check("R10 counter holds when stopped", d2, d1);
        check("R10 no events when stopped", ha, la ? 20 : 0);
        wr(3'd4, C_START | C_STOP);
        repeat (20) @(negedge clk);
        rd(3'd5, d2);
        check("R10 start plus stop stays stopped", d2, d1);
        wr(3'd0, mode_word(0, CLR, SET, CLR, NONE, NONE, NONE));
        wr(3'd4, C_TRIG);
        check("R10 trigger while stopped applies action", out_a, 0);
        wr(3'd0, mode_word(0, CLR, SET, SET, NONE, NONE, NONE));
        wr(3'd4, C_START | C_STOP | C_TRIG);
        check("R10 trigger in stop write applies action", out_a, 1);
        repeat (20) @(negedge clk);
        rd(3'd5, d2);
        check("R10 trigger in stop write zeroes and holds", d2, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_pwm();
        t_divs();
        t_slow();
        t_wrap();
        t_prio_trig();
        t_prio_cmp();
        t_toggle();
        t_steady();
        t_stop();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule